// File: doc/BRIEF.md
# UART Receive Holding Queue with Break Insertion

This block holds received characters for one UART channel between the serial deserializer and the register file. Characters arrive through a push port that is gated by a ready signal, and they leave oldest-first through a pop port that the register read logic strobes. The block keeps three status flags: data available, queue full, and a sticky break-change flag.

A detected line break always stores a zero character, even when normal reception is disabled or the queue is full. When the queue is full, that zero replaces the most recently stored character, so the break is never lost. A flush input clears the stored characters when the receiver is reset. A separate clear input drops the break-change flag.

All flags are registered. Each flag moves on the clock edge that follows the push, pop or flush that changes it. The pop data output is combinational and always shows the oldest character, or zero when the queue is empty.

Top module: `rx_break_fifo`

## Requirements
- R1: Characters leave in the order they were stored. `pop_data_o` always shows the oldest stored character.
- R2: `push_ready_o` is high exactly when `rx_en_i` is high, `full_o` is low and `brk_i` is low.
- R3: Any stored character, whether a normal push or a break zero, makes `rdy_o` high after the clock edge, unless `flush_i` is high in that cycle.
- R4: `full_o` goes high on the edge at which the stored count reaches DEPTH (4 by default). It never exceeds DEPTH.
- R5: A pop removes the oldest character. A pop without a break in the same cycle leaves `full_o` low afterwards.
- R6: `rdy_o` stays high after a pop unless the count drops to zero.
- R7: While the queue is empty, `pop_data_o` reads 0x00. A pop on an empty queue changes no flag and no stored state.
- R8: `brk_i` sets `dbrk_o` on the next edge and stores a 0x00 character, whether or not `rx_en_i` is high.
- R9: A break while the queue is full overwrites the newest character with 0x00. The count stays at DEPTH and `full_o` stays high.
- R10: `flush_i` empties the queue and clears `rdy_o` and `full_o`. It wins over a push, pop or break in the same cycle, but it does not clear `dbrk_o`.
- R11: A pop and a push in the same cycle first return the old head and then store the new character. The count is unchanged and no character is lost.
- R12: `dbrk_clr_i` clears `dbrk_o`. A simultaneous `brk_i` takes precedence.
- R13: After reset, `rdy_o`, `full_o` and `dbrk_o` are low and `pop_data_o` is 0x00.
- R14: A normal push offered while `push_ready_o` is low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enabled |
| push_valid_i | input | 1 | Deserializer offers a character |
| push_data_i | input | WIDTH | Offered character |
| push_ready_o | output | 1 | Normal character will be accepted this cycle |
| brk_i | input | 1 | Line break detected (one-cycle event) |
| pop_i | input | 1 | Register read consumes the head character |
| pop_data_o | output | WIDTH | Head character, zero when empty |
| flush_i | input | 1 | Receiver reset: discard contents |
| dbrk_clr_i | input | 1 | Clear the break-change flag |
| rdy_o | output | 1 | Data available flag |
| full_o | output | 1 | Queue full flag |
| dbrk_o | output | 1 | Break-change flag |

## Verification
The bench builds the block with DEPTH 4 and WIDTH 8. This small depth means a few pushes reach the full state, so break overwrites, simultaneous pop and push at the full and empty edges, and flushes during every fill level come up often in a long pseudo-random sweep. A queue model in the bench predicts every popped byte and every flag, including the zero returned by empty reads. Directed sequences before the sweep hit each corner case once on purpose.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl import rxf_pkg::*; #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic             push_acc_i,
  input  logic             brk_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_nxt;
  logic             pop_do;
  wr_kind_e         wr_kind;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_LAST : p - PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign pop_do  = pop_i & ~empty_o;
  // pop is served from the old contents before any write lands
  assign cnt_mid = cnt_q - CNT_W'(pop_do);

  always_comb begin
    wr_kind = WR_NONE;
    if (!flush_i) begin
      if (brk_i)           wr_kind = (cnt_mid == CNT_MAX) ? WR_REPLACE : WR_APPEND;
      else if (push_acc_i) wr_kind = WR_APPEND;
    end
  end

  assign wr_en_o   = (wr_kind != WR_NONE);
  assign wr_idx_o  = (wr_kind == WR_REPLACE) ? ptr_dec(wr_ptr_q) : wr_ptr_q;
  assign cnt_nxt   = flush_i ? '0 : cnt_mid + CNT_W'(wr_kind == WR_APPEND);
  assign cnt_nxt_o = cnt_nxt;
  assign cnt_o     = cnt_q;
  assign rd_ptr_o  = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (flush_i) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
      end else begin
        if (pop_do)                rd_ptr_q <= ptr_inc(rd_ptr_q);
        if (wr_kind == WR_APPEND)  wr_ptr_q <= ptr_inc(wr_ptr_q);
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_replace_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind == WR_REPLACE) |=> (cnt_q == CNT_MAX));
  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
  p_pop_push_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_do && wr_kind == WR_APPEND && !flush_i) |=> (cnt_q == $past(cnt_q)));
  p_empty_pop_noop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !brk_i && !push_acc_i && !flush_i)
      |=> (cnt_q == '0) && $stable(rd_ptr_q) && $stable(wr_ptr_q));
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [DEPTH*WIDTH-1:0] slots_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q <= '0;
      else if (wr_en_i && wr_idx_i == PTR_W'(g))     slot_q <= wr_data_i;
    end
    assign slots_flat[g*WIDTH +: WIDTH] = slot_q;
  end

  assign rd_data_o = slots_flat[rd_idx_i*WIDTH +: WIDTH];

  p_rd_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_idx_i) < DEPTH);
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             brk_i,
  input  logic             dbrk_clr_i,
  output logic             rdy_o,
  output logic             full_o,
  output logic             dbrk_o
);
  logic rdy_q, full_q, dbrk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
      dbrk_q <= 1'b0;
    end else begin
      rdy_q  <= (cnt_nxt_i != '0);
      full_q <= (cnt_nxt_i == CNT_W'(DEPTH));
      if (brk_i)           dbrk_q <= 1'b1;
      else if (dbrk_clr_i) dbrk_q <= 1'b0;
    end
  end

  assign rdy_o  = rdy_q;
  assign full_o = full_q;
  assign dbrk_o = dbrk_q;

  p_full_implies_rdy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> rdy_q);
endmodule

// File: rtl/rx_break_fifo.sv
module rx_break_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             push_valid_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             push_ready_o,
  input  logic             brk_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  input  logic             flush_i,
  input  logic             dbrk_clr_i,
  output logic             rdy_o,
  output logic             full_o,
  output logic             dbrk_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] rd_ptr, wr_idx;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             wr_en, empty, push_acc;
  logic [WIDTH-1:0] rd_data, wr_data;

  assign push_ready_o = rx_en_i & ~full_o & ~brk_i;
  assign push_acc     = push_valid_i & push_ready_o;
  assign wr_data      = brk_i ? '0 : push_data_i;
  assign pop_data_o   = empty ? '0 : rd_data;

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .flush_i, .pop_i,
    .push_acc_i (push_acc),
    .brk_i,
    .rd_ptr_o   (rd_ptr),
    .wr_idx_o   (wr_idx),
    .wr_en_o    (wr_en),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .empty_o    (empty)
  );

  rxf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_ptr),
    .rd_data_o (rd_data)
  );

  rxf_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni,
    .cnt_nxt_i (cnt_nxt),
    .brk_i, .dbrk_clr_i,
    .rdy_o, .full_o, .dbrk_o
  );

  p_ready_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ready_o |-> (rx_en_i && !full_o && !brk_i));
  p_push_sets_rdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((push_acc || brk_i) && !flush_i) |=> rdy_o);
  p_fill_sets_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(DEPTH - 1) && push_acc && !pop_i && !flush_i) |=> full_o);
  p_pop_clears_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pop_i && !brk_i) |=> !full_o);
  p_rdy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt > CNT_W'(1) && !flush_i) |=> rdy_o);
  p_empty_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> (pop_data_o == '0));
  p_brk_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> dbrk_o);
  p_brk_full_stays_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && brk_i && !pop_i && !flush_i) |=> full_o);
  p_flush_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!rdy_o && !full_o));
  p_clr_dbrk_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbrk_clr_i && !brk_i) |=> !dbrk_o);
  p_drop_blocked_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_valid_i && !brk_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: tb/sim_rx_break_fifo.sv
`timescale 1ns/1ps
module sim_rx_break_fifo;
  localparam int D = 4;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, push_v = 1'b0, brk = 1'b0, pop = 1'b0, flush = 1'b0, clr = 1'b0;
  logic [W-1:0] push_d = '0;
  logic push_ready, rdy, full, dbrk;
  logic [W-1:0] pop_data;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] mq[$];
  logic m_dbrk = 1'b0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  rx_break_fifo #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .push_valid_i(push_v),
    .push_data_i(push_d), .push_ready_o(push_ready), .brk_i(brk), .pop_i(pop),
    .pop_data_o(pop_data), .flush_i(flush), .dbrk_clr_i(clr),
    .rdy_o(rdy), .full_o(full), .dbrk_o(dbrk)
  );

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic cyc(input logic pv, input logic [W-1:0] pd, input logic bk, input logic pp,
                     input logic fl, input logic cl, input logic en, input string tag);
    logic exp_ready;
    @(negedge clk);
    push_v = pv; push_d = pd; brk = bk; pop = pp; flush = fl; clr = cl; rx_en = en;
    #1;
    exp_ready = en && (mq.size() != D) && !bk;
    chk("R2 push_ready", {7'd0, push_ready}, {7'd0, exp_ready});
    if (pp) chk({tag, " pop_data"}, pop_data, (mq.size() != 0) ? mq[0] : '0);
    @(posedge clk);
    #1;
    if (fl) mq.delete();
    else begin
      if (pp && mq.size() != 0) void'(mq.pop_front());
      if (bk) begin
        if (mq.size() == D) mq[D-1] = '0;
        else mq.push_back('0);
      end else if (pv && exp_ready) mq.push_back(pd);
    end
    if (bk) m_dbrk = 1'b1;
    else if (cl) m_dbrk = 1'b0;
    chk({tag, " rdy"},  {7'd0, rdy},  {7'd0, mq.size() != 0});
    chk({tag, " full"}, {7'd0, full}, {7'd0, mq.size() == D});
    chk({tag, " dbrk"}, {7'd0, dbrk}, {7'd0, m_dbrk});
    if (mq.size() == 0) chk("R7 idle data", pop_data, '0);
    else chk("R1 head", pop_data, mq[0]);
  endtask

  task automatic push1(input logic [W-1:0] d, input string tag);
    cyc(1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask
  task automatic pop1(input string tag);
    cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    chk("R13 rdy", {7'd0, rdy}, 8'd0);
    chk("R13 full", {7'd0, full}, 8'd0);
    chk("R13 dbrk", {7'd0, dbrk}, 8'd0);
    chk("R13 pop_data", pop_data, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R14: offered byte with receiver disabled is dropped
    cyc(1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R14");
    // R3 / R4: fill to full
    push1(8'hA1, "R3");
    push1(8'hA2, "R4");
    push1(8'hA3, "R4");
    push1(8'hA4, "R4");
    push1(8'hA5, "R14");
    // R9: break when full overwrites newest
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    pop1("R1"); pop1("R6"); pop1("R1"); pop1("R1");
    // R7: empty pops
    pop1("R7"); pop1("R7");
    // R12: clear break flag
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R12");
    // R8: break with receiver off on empty queue, then clear vs break same cycle
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R12");
    pop1("R8");
    // R11: pop and push same cycle
    push1(8'h21, "R11"); push1(8'h22, "R11");
    cyc(1'b1, 8'h23, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
    push1(8'h24, "R11"); push1(8'h25, "R11");
    // R5: pop while full, with a push offered (blocked by full)
    cyc(1'b1, 8'h26, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    // R9: full + pop + break lands in the freed slot
    push1(8'h27, "R4");
    cyc(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
    // R10: flush with a break and push pending
    cyc(1'b1, 8'h31, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R10");
    push1(8'h32, "R10");
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R10");
    pop1("R7");

    // pseudo-random sweep in three bias phases
    for (int ph = 0; ph < 3; ph++) begin
      for (int n = 0; n < 15000; n++) begin
        logic [31:0] r;
        logic pv, pp;
        r = rnd();
        pv = (ph == 0) ? (r[2:0] != 3'd0) : (ph == 1) ? r[0] : (r[2:0] == 3'd0);
        pp = (ph == 0) ? (r[5:3] == 3'd0) : (ph == 1) ? r[3] : (r[5:3] != 3'd0);
        cyc(pv, r[15:8], r[19:16] == 4'd0, pp, r[25:20] == 6'd0,
            r[29:26] == 4'd0, r[31:28] != 4'd0, "R1");
      end
    end

    @(negedge clk);
    push_v = 0; brk = 0; pop = 0; flush = 0; clr = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule